// File: doc/BRIEF.md
# Two's-Complement Floating-Point Normalizer

This unit takes one 16-bit floating-point word and hands back the same value in normalized form. The upper twelve bits are a two's-complement fraction with its binary point right after the sign bit. The lower four bits are a two's-complement exponent. A value is normalized when the sign bit and the first fraction bit differ, so a positive value reads 0.1… and a negative value reads 1.0…. While the two bits are equal, the unit moves the fraction left by one place and lowers the exponent by one, one step per clock.

A client places a word on the input and raises `start` while the unit is idle. `busy` then stays high while the unit works, and `done` pulses for one cycle when the result word and its two flags are valid. An all-zero fraction cannot be normalized. The unit returns it at once with a zero exponent and raises the zero flag. If the exponent has already reached its most negative value and the word is still unnormalized, the unit stops, keeps that word and raises the underflow flag. The result and the flags hold their values until the next job completes.

Top module: `tcfn_normalizer`

## Requirements
- R1: Input and output words share one layout. The fraction sits in bits 15..4 with its sign in bit 15. The exponent is a two's-complement integer in bits 3..0 (range -8..+7).
- R2: A completed result that is neither zero nor underflow has bit 15 different from bit 14.
- R3: Each adjustment step shifts the fraction left by one, puts 0 in bit 4 of the word and lowers the exponent by one. A job that needs n steps raises `done` at the clock edge that comes n+1 edges after the edge that sampled `start`.
- R4: An all-zero fraction is never shifted. The result is 0x0000 with `flag_zero` = 1 and `flag_underflow` = 0, and `done` comes one edge after `start` is sampled.
- R5: When the exponent equals -8 (0b1000) and the fraction is still unnormalized, the unit finishes with the current word unchanged, `flag_underflow` = 1 and `flag_zero` = 0.
- R6: An input that is already normalized finishes one edge after `start` is sampled. Its word is unchanged and both flags are 0.
- R7: `start` is sampled only while `busy` is 0. `busy` is 1 from the edge after acceptance until the edge on which `done` rises. `done` is high for exactly one cycle, and `busy` and `done` are never high together.
- R8: After a synchronous reset, `busy`, `done`, both flags and `out_word` are all 0.
- R9: An all-ones fraction (0xFFF) takes 11 steps and becomes 0x800, provided the exponent stays at -8 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to normalize `in_word`; used only while idle |
| in_word | input | 16 | Fraction in 15..4, exponent in 3..0 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| out_word | output | 16 | Normalized word in the input's layout |
| flag_zero | output | 1 | The last result had an all-zero fraction |
| flag_underflow | output | 1 | The last result stopped at exponent -8 while unnormalized |

## Verification
The assertions assume that `rst` is held for at least one edge before the first job. They also assume that the client watches `busy` and does not expect a `start` raised during a job to be queued. The stimulus waits for `busy` to drop before it relies on a new request. One phase holds `start` high for many cycles on purpose, to show that a request made during a job is dropped and that only the level seen while idle counts. Input words are either hand-picked corner cases or random 16-bit values, so every exponent, including those that lead to underflow, can occur.

// File: rtl/tcfn_pkg.sv
package tcfn_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tcfn_state_e;
endpackage

// File: rtl/tcfn_form_check.sv
module tcfn_form_check #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic              is_zero,
  output logic              is_norm,
  output logic              exp_floor
);
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  always_comb begin
    is_zero   = (mant == '0);
    is_norm   = mant[MANT_W-1] ^ mant[MANT_W-2];
    exp_floor = (expo == EXP_MIN);
  end
endmodule

// File: rtl/tcfn_shift_step.sv
module tcfn_shift_step #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [MANT_W-1:0] mant_nxt,
  output logic [EXP_W-1:0]  expo_nxt
);
  always_comb begin
    mant_nxt = {mant[MANT_W-2:0], 1'b0};
    expo_nxt = expo - 1'b1;
  end
endmodule

// File: rtl/tcfn_ctrl.sv
module tcfn_ctrl
  import tcfn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_zero,
  input  logic is_norm,
  input  logic exp_floor,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  tcfn_state_e state_q;

  always_comb begin
    load   = (state_q == ST_IDLE) && start;
    finish = (state_q == ST_RUN) && (is_zero || is_norm || exp_floor);
    step   = (state_q == ST_RUN) && !(is_zero || is_norm || exp_floor);
    busy   = (state_q == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_RUN;
        ST_RUN: if (finish) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: busy and done never overlap
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: done only follows a cycle of work
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // R7: a request while working does not restart the job
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !finish) |=> busy);
endmodule

// File: rtl/tcfn_normalizer.sv
module tcfn_normalizer #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [MANT_W+EXP_W-1:0]   in_word,
  output logic                      busy,
  output logic                      done,
  output logic [MANT_W+EXP_W-1:0]   out_word,
  output logic                      flag_zero,
  output logic                      flag_underflow
);
  localparam int WORD_W = MANT_W + EXP_W;
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic [MANT_W-1:0] work_mant, mant_nxt, out_mant;
  logic [EXP_W-1:0]  work_exp, exp_nxt, out_exp;
  logic is_zero, is_norm, exp_floor;
  logic load, step, finish;

  tcfn_form_check #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_form (
    .mant(work_mant), .expo(work_exp),
    .is_zero(is_zero), .is_norm(is_norm), .exp_floor(exp_floor)
  );

  tcfn_shift_step #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_step (
    .mant(work_mant), .expo(work_exp),
    .mant_nxt(mant_nxt), .expo_nxt(exp_nxt)
  );

  tcfn_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .is_zero(is_zero), .is_norm(is_norm), .exp_floor(exp_floor),
    .load(load), .step(step), .finish(finish),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      work_mant      <= '0;
      work_exp       <= '0;
      out_mant       <= '0;
      out_exp        <= '0;
      flag_zero      <= 1'b0;
      flag_underflow <= 1'b0;
    end else begin
      if (load) begin
        work_mant <= in_word[WORD_W-1:EXP_W];
        work_exp  <= in_word[EXP_W-1:0];
      end else if (step) begin
        work_mant <= mant_nxt;
        work_exp  <= exp_nxt;
      end
      if (finish) begin
        out_mant       <= is_zero ? '0 : work_mant;
        out_exp        <= is_zero ? '0 : work_exp;
        flag_zero      <= is_zero;
        flag_underflow <= !is_zero && !is_norm;
      end
    end
  end

  assign out_word = {out_mant, out_exp};

  // R2: ordinary results leave in normalized form
  p_norm_form_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_zero && !flag_underflow) |->
      (out_word[WORD_W-1] != out_word[WORD_W-2]));
  // R3: each step lowers the exponent by exactly one
  p_step_exp_r3: assert property (@(posedge clk) disable iff (rst)
    step |=> (work_exp == $past(work_exp) - 1'b1));
  // R3: each step brings a zero into the lowest fraction bit
  p_step_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    step |=> (work_mant[0] == 1'b0));
  // R4: a zero result carries a zero word and no underflow
  p_zero_word_r4: assert property (@(posedge clk) disable iff (rst)
    (done && flag_zero) |-> (out_word == '0 && !flag_underflow));
  // R5: underflow stops with the exponent at its floor
  p_floor_exp_r5: assert property (@(posedge clk) disable iff (rst)
    (done && flag_underflow) |-> (out_exp == EXP_MIN));
endmodule

// File: tb/tcfn_normalizer_test.sv
module tcfn_normalizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 12;
  localparam int EW = 4;
  localparam int WW = MW + EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic busy, done, flag_zero, flag_underflow;
  logic [WW-1:0] out_word;

  int n_checks = 0;
  int n_fails = 0;
  bit began = 0;
  string cur_req = "R8";

  // behavioural reference state
  bit m_busy = 0, m_done = 0, m_zf = 0, m_uf = 0;
  bit p_zf, p_uf;
  int m_left = 0;
  logic [WW-1:0] m_word = '0, p_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcfn_normalizer #(.MANT_W(MW), .EXP_W(EW)) uut (
    .clk(clk), .rst(rst), .start(start), .in_word(in_word),
    .busy(busy), .done(done), .out_word(out_word),
    .flag_zero(flag_zero), .flag_underflow(flag_underflow)
  );

  function automatic void ref_eval(input logic [WW-1:0] w, output logic [WW-1:0] rw,
                                   output bit zf, output bit uf, output int n);
    int m, e;
    m = int'(w[WW-1:EW]);
    e = int'($signed(w[EW-1:0]));
    zf = 0; uf = 0; n = 0;
    if (m == 0) begin
      zf = 1; e = 0;
    end else begin
      while (((m >> (MW-1)) & 1) == ((m >> (MW-2)) & 1)) begin
        if (e == -(1 << (EW-1))) begin uf = 1; break; end
        m = (m << 1) & ((1 << MW) - 1);
        e = e - 1;
        n = n + 1;
      end
    end
    rw = {m[MW-1:0], e[EW-1:0]};
  endfunction

  always @(posedge clk) begin
    began <= 1;
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_left <= 0;
      m_word <= '0; m_zf <= 0; m_uf <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy && start) begin
        int n;
        ref_eval(in_word, p_word, p_zf, p_uf, n);
        m_busy <= 1;
        m_left <= n;
      end else if (m_busy) begin
        if (m_left == 0) begin
          m_busy <= 0; m_done <= 1;
          m_word <= p_word; m_zf <= p_zf; m_uf <= p_uf;
        end else m_left <= m_left - 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (began) begin
      string ctl;
      ctl = rst ? "R8" : "R7";
      check(ctl, "busy", WW'(busy), WW'(m_busy));
      check(ctl, "done", WW'(done), WW'(m_done));
      check(rst ? "R8" : cur_req, "out_word(R1 layout)", out_word, m_word);
      check(rst ? "R8" : "R4", "flag_zero", WW'(flag_zero), WW'(m_zf));
      check(rst ? "R8" : "R5", "flag_underflow", WW'(flag_underflow), WW'(m_uf));
    end
  end

  task automatic run_word(input logic [WW-1:0] w, input int gap);
    @(negedge clk);
    in_word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy || m_done) @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R6";
    run_word(16'h4A03, 1);          // R6: positive 0.1..., no change
    run_word(16'hB00C, 0);          // R6: negative 1.0...
    cur_req = "R4";
    run_word(16'h0005, 2);          // R4: zero fraction, exponent forced to 0
    run_word(16'h000F, 0);
    cur_req = "R3";
    run_word(16'h0017, 1);          // R3: 10 steps, exp 7 -> -3
    run_word(16'hF003, 1);          // R3: negative needs 3 steps
    cur_req = "R9";
    run_word(16'hFFF7, 1);          // R9: 11 steps to 0x800, exp -4
    cur_req = "R5";
    run_word(16'h001A, 1);          // R5: exp -6, stops after 2 steps
    run_word(16'h1238, 1);          // R5: already at floor
    cur_req = "R7";
    @(negedge clk);
    in_word = 16'h0017; start = 1'b1;
    @(negedge clk);
    in_word = 16'h0005;             // R7: change while busy must be ignored
    repeat (20) @(negedge clk);
    start = 1'b0;
    while (m_busy || m_done) @(negedge clk);
    cur_req = "R1";
    for (int i = 0; i < 400; i++) run_word(WW'($urandom), $urandom_range(0, 2));
    cur_req = "R8";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule